// File: doc/BRIEF.md
# Pointer Authentication Check Unit

This block checks a return address that carries an authentication code in its upper bits. The requester gives it the signed 64-bit pointer and a 64-bit code value that has already been computed. It also supplies the 64-bit translation-control word, the host-extension mode bit, a key-select bit (key A or key B), the enable bit of each key, and a flag that says whether the enhanced failure scheme is implemented. From the pointer's bit 55 and the control word, the unit works out which bits hold the code. It then rebuilds the canonical address and compares the code bits. It returns a pass flag and the address that execution should resume at.

The unit is used as one stage of an exception-return path. A request is accepted through a valid/ready pair, and the verdict comes back from registers one cycle later. A two-state controller holds the response until it is consumed. `ST_IDLE` (ready high, no response) moves to `ST_HOLD` on the transition *accept* (valid and ready both high). `ST_HOLD` (response valid, ready low) returns to `ST_IDLE` on the transition *consume* (response ready high). In every other case each state stays where it is. Because of this, a new request cannot be accepted in the same cycle as the previous response is consumed.

Top module: `pac_check_unit`

## Requirements
- R1: In host-extension mode (`req_host_ext`=1), pointer bit 55 picks the settings. When bit 55 is 0 the unit uses the lower-half settings: size field at control bits 5:0, TBI at bit 37, TBID at bit 51. When bit 55 is 1 it uses the upper-half settings: size field at bits 21:16, TBI at bit 38, TBID at bit 52.
- R2: When `req_host_ext`=0, pointer bit 55 is ignored. The unit then uses the size field at bits 5:0, TBI at control bit 20 and TBID at control bit 29.
- R3: Top-byte-ignore is effective only when the selected TBI is 1 and the selected TBID is 0. When it is not effective, the code mask also covers bits 63:56.
- R4: The selected size field is clamped to the range 16..39. The code mask covers bits 54 down to (64 − clamped size). Bit 55 is never in the mask.
- R5: The canonical address is the pointer with every masked bit set when bit 55 is 1, and with every masked bit cleared when bit 55 is 0. On a pass, the canonical address is returned.
- R6: Authentication passes when the code value and the pointer agree on every masked bit.
- R7: When the enable bit of the selected key is 0, the result is a pass and the pointer is returned unchanged, whatever the code value is.
- R8: On a failure with `req_enh`=0, the canonical address is returned with a 2-bit error code written into it: 1 for key A, 2 for key B. The code goes in bits 54:53 when top-byte-ignore is effective, and in bits 62:61 otherwise.
- R9: On a failure with `req_enh`=1, the returned address is the pointer XOR (code AND mask), and the pass flag is 0.
- R10: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `rsp_valid` is high from the next cycle on. `req_ready` stays low, and `rsp_addr`/`rsp_pass` stay stable, until a cycle with `rsp_ready` high consumes the response.
- R11: The synchronous active-high `rst` clears `rsp_valid`, `rsp_addr` and `rsp_pass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_ptr | input | 64 | Signed pointer |
| req_code | input | 64 | Precomputed authentication code value |
| req_tctl | input | 64 | Translation-control word |
| req_host_ext | input | 1 | Host-extension mode |
| req_key_b | input | 1 | 0 selects key A, 1 selects key B |
| req_en_a | input | 1 | Key A enable |
| req_en_b | input | 1 | Key B enable |
| req_enh | input | 1 | Enhanced failure scheme implemented |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_pass | output | 1 | Authentication passed |
| rsp_addr | output | 64 | Address to return to |

## Verification
The in-RTL properties check the handshake on every cycle. They cover the response appearing one cycle after an accept, `req_ready` staying low while a response is pending, and the response holding stable until it is consumed. They also cover the reset clearing and two invariants: the mask stays below the clamped lower bound, and a pass keeps pointer bit 55. Only the bench scenarios can show that the mask and canonical value are right for each field selection. The same holds for size clamping at both ends, the key-specific error code and its position, the enhanced XOR result, and the disabled-key pass-through, because these depend on exact expected addresses.

// File: rtl/pac_check_pkg.sv
package pac_check_pkg;

    localparam int unsigned XLEN = 64;

    // Translation-control word field positions
    localparam int unsigned LO_SZ_LSB  = 0;
    localparam int unsigned HI_SZ_LSB  = 16;
    localparam int unsigned SZ_W       = 6;
    localparam int unsigned LO_TBI     = 37;
    localparam int unsigned HI_TBI     = 38;
    localparam int unsigned LO_TBID    = 51;
    localparam int unsigned HI_TBID    = 52;
    localparam int unsigned SOLO_TBI   = 20;
    localparam int unsigned SOLO_TBID  = 29;

    // Pointer layout
    localparam int unsigned HALF_BIT   = 55;
    localparam int unsigned CODE_TOP   = 54;
    localparam int unsigned TOPBYTE_LO = 56;
    localparam int unsigned ERR_LO_TBI = 53;
    localparam int unsigned ERR_LO_ALL = 61;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } hs_state_t;

    typedef logic [1:0] err_code_t;
    localparam err_code_t ERR_KEY_A = 2'd1;
    localparam err_code_t ERR_KEY_B = 2'd2;

endpackage

// File: rtl/pac_mask_gen.sv
module pac_mask_gen
    import pac_check_pkg::*;
#(
    parameter int unsigned SZ_MIN = 16,
    parameter int unsigned SZ_MAX = 39
) (
    input  logic [XLEN-1:0] tctl,
    input  logic            host_ext,
    input  logic            hi_half,
    output logic [XLEN-1:0] mask,
    output logic            tbi_eff
);

    localparam int unsigned BOT_W = SZ_W + 1;
    localparam logic [SZ_W-1:0] MIN_V = SZ_W'(SZ_MIN);
    localparam logic [SZ_W-1:0] MAX_V = SZ_W'(SZ_MAX);

    logic              use_hi;
    logic              tbi_sel;
    logic              tbid_sel;
    logic [SZ_W-1:0]   sz_raw;
    logic [SZ_W-1:0]   sz_clamped;
    logic [BOT_W-1:0]  bottom;

    assign use_hi = host_ext && hi_half;

    always_comb begin
        if (!host_ext) begin
            tbi_sel  = tctl[SOLO_TBI];
            tbid_sel = tctl[SOLO_TBID];
        end else if (hi_half) begin
            tbi_sel  = tctl[HI_TBI];
            tbid_sel = tctl[HI_TBID];
        end else begin
            tbi_sel  = tctl[LO_TBI];
            tbid_sel = tctl[LO_TBID];
        end
    end

    assign tbi_eff = tbi_sel && !tbid_sel;

    assign sz_raw = use_hi ? tctl[HI_SZ_LSB +: SZ_W] : tctl[LO_SZ_LSB +: SZ_W];

    always_comb begin
        if (sz_raw < MIN_V)
            sz_clamped = MIN_V;
        else if (sz_raw > MAX_V)
            sz_clamped = MAX_V;
        else
            sz_clamped = sz_raw;
    end

    assign bottom = BOT_W'(XLEN) - {1'b0, sz_clamped};

    for (genvar i = 0; i < XLEN; i++) begin : g_mask
        if (i <= CODE_TOP) begin : g_code
            assign mask[i] = (BOT_W'(i) >= bottom);
        end else if (i == HALF_BIT) begin : g_half
            assign mask[i] = 1'b0;
        end else begin : g_top
            assign mask[i] = !tbi_eff;
        end
    end

    // Remaining control bits are decoded elsewhere in the chip
    logic unused_tctl;
    assign unused_tctl = ^{tctl[63:53], tctl[50:39], tctl[36:30], tctl[28:22], tctl[19], tctl[15:6]};

    // R4
    localparam int unsigned LOW_FREE = XLEN - SZ_MAX;
    always_comb begin
        mask_floor_chk: assert (mask[LOW_FREE-1:0] == '0);
    end

endmodule

// File: rtl/pac_verdict.sv
module pac_verdict
    import pac_check_pkg::*;
(
    input  logic [XLEN-1:0] ptr,
    input  logic [XLEN-1:0] code,
    input  logic [XLEN-1:0] mask,
    input  logic            tbi_eff,
    input  logic            key_b,
    input  logic            key_en,
    input  logic            enh,
    output logic            pass,
    output logic [XLEN-1:0] addr
);

    logic [XLEN-1:0] canon;
    logic [XLEN-1:0] corrupt;
    logic            match;
    err_code_t       ecode;

    assign canon = ptr[HALF_BIT] ? (ptr | mask) : (ptr & ~mask);
    assign match = ((code ^ ptr) & mask) == '0;
    assign ecode = key_b ? ERR_KEY_B : ERR_KEY_A;

    always_comb begin
        corrupt = canon;
        if (tbi_eff)
            corrupt[ERR_LO_TBI +: 2] = ecode;
        else
            corrupt[ERR_LO_ALL +: 2] = ecode;
    end

    always_comb begin
        if (!key_en) begin
            pass = 1'b1;
            addr = ptr;
        end else if (match) begin
            pass = 1'b1;
            addr = canon;
        end else if (enh) begin
            pass = 1'b0;
            addr = ptr ^ (code & mask);
        end else begin
            pass = 1'b0;
            addr = corrupt;
        end
    end

    // R5
    always_comb begin
        pass_half_chk: assert (!pass || (addr[HALF_BIT] == ptr[HALF_BIT]));
    end

endmodule

// File: rtl/pac_check_unit.sv
module pac_check_unit
    import pac_check_pkg::*;
#(
    parameter int unsigned SZ_MIN = 16,
    parameter int unsigned SZ_MAX = 39
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [XLEN-1:0] req_ptr,
    input  logic [XLEN-1:0] req_code,
    input  logic [XLEN-1:0] req_tctl,
    input  logic            req_host_ext,
    input  logic            req_key_b,
    input  logic            req_en_a,
    input  logic            req_en_b,
    input  logic            req_enh,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic            rsp_pass,
    output logic [XLEN-1:0] rsp_addr
);

    hs_state_t       state_q;
    hs_state_t       state_d;
    logic            accept;
    logic [XLEN-1:0] mask;
    logic            tbi_eff;
    logic            v_pass;
    logic [XLEN-1:0] v_addr;

    pac_mask_gen #(
        .SZ_MIN (SZ_MIN),
        .SZ_MAX (SZ_MAX)
    ) u_mask (
        .tctl     (req_tctl),
        .host_ext (req_host_ext),
        .hi_half  (req_ptr[HALF_BIT]),
        .mask     (mask),
        .tbi_eff  (tbi_eff)
    );

    pac_verdict u_verdict (
        .ptr     (req_ptr),
        .code    (req_code),
        .mask    (mask),
        .tbi_eff (tbi_eff),
        .key_b   (req_key_b),
        .key_en  (req_key_b ? req_en_b : req_en_a),
        .enh     (req_enh),
        .pass    (v_pass),
        .addr    (v_addr)
    );

    assign accept = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_HOLD;
            ST_HOLD: if (rsp_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_pass <= 1'b0;
            rsp_addr <= '0;
        end else if (accept) begin
            rsp_pass <= v_pass;
            rsp_addr <= v_addr;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_HOLD);

    // R10
    accept_resp_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> rsp_valid);

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_pass)));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !rsp_pass && rsp_addr == '0));

endmodule

// File: tb/pac_check_unit_tb.sv
module pac_check_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_ptr = '0;
    logic [63:0] req_code = '0;
    logic [63:0] req_tctl = '0;
    logic        req_host_ext = 1'b0;
    logic        req_key_b = 1'b0;
    logic        req_en_a = 1'b0;
    logic        req_en_b = 1'b0;
    logic        req_enh = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_pass;
    logic [63:0] rsp_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pac_check_unit u_dut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_ptr      (req_ptr),
        .req_code     (req_code),
        .req_tctl     (req_tctl),
        .req_host_ext (req_host_ext),
        .req_key_b    (req_key_b),
        .req_en_a     (req_en_a),
        .req_en_b     (req_en_b),
        .req_enh      (req_enh),
        .rsp_valid    (rsp_valid),
        .rsp_ready    (rsp_ready),
        .rsp_pass     (rsp_pass),
        .rsp_addr     (rsp_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_tctl(input int lo_sz, input int hi_sz,
                                            input bit tbi_lo, input bit tbi_hi,
                                            input bit tbid_lo, input bit tbid_hi,
                                            input bit tbi_solo, input bit tbid_solo);
        logic [63:0] t = '0;
        t[5:0]   = 6'(lo_sz);
        t[21:16] = 6'(hi_sz);
        t[37] = tbi_lo;  t[38] = tbi_hi;
        t[51] = tbid_lo; t[52] = tbid_hi;
        t[20] = tbi_solo; t[29] = tbid_solo;
        return t;
    endfunction

    // Expected result from the requirement text: {pass, addr}
    function automatic logic [64:0] model(input logic [63:0] p, input logic [63:0] c,
                                          input logic [63:0] t, input bit hx, input bit kb,
                                          input bit ea, input bit eb, input bit en);
        bit hi, tbi, tbid, eff;
        int sz, bot;
        logic [63:0] m, can, r;
        hi = hx && p[55];
        if (!hx)     begin tbi = t[20]; tbid = t[29]; end
        else if (hi) begin tbi = t[38]; tbid = t[52]; end
        else         begin tbi = t[37]; tbid = t[51]; end
        eff = tbi && !tbid;
        sz = hi ? int'(t[21:16]) : int'(t[5:0]);
        if (sz < 16) sz = 16;
        if (sz > 39) sz = 39;
        bot = 64 - sz;
        m = '0;
        for (int i = bot; i <= 54; i++) m[i] = 1'b1;
        if (!eff) m[63:56] = 8'hFF;
        can = p[55] ? (p | m) : (p & ~m);
        if (!(kb ? eb : ea)) return {1'b1, p};
        if (((p ^ c) & m) == 0) return {1'b1, can};
        if (en) return {1'b0, p ^ (c & m)};
        r = can;
        if (eff) r[54:53] = kb ? 2'd2 : 2'd1;
        else     r[62:61] = kb ? 2'd2 : 2'd1;
        return {1'b0, r};
    endfunction

    // One transaction; checks the response against exp_addr/exp_pass
    task automatic run_req(input string tag, input logic [63:0] p, input logic [63:0] c,
                           input logic [63:0] t, input bit hx, input bit kb,
                           input bit ea, input bit eb, input bit en,
                           input logic [63:0] exp_addr, input bit exp_pass, input int stall);
        @(negedge clk);
        chk(req_ready === 1'b1, {tag, " R10 ready idle"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_ptr = p; req_code = c; req_tctl = t;
        req_host_ext = hx; req_key_b = kb; req_en_a = ea; req_en_b = eb; req_enh = en;
        @(negedge clk);
        req_valid = 1'b1;
        req_ptr = ~p;
        for (int s = 0; s < stall; s++) begin
            chk(rsp_valid === 1'b1 && req_ready === 1'b0, {tag, " R10 pending"}, 64'(rsp_valid), 64'd1);
            chk(rsp_addr === exp_addr, {tag, " R10 hold addr"}, rsp_addr, exp_addr);
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, {tag, " R10 rsp valid"}, 64'(rsp_valid), 64'd1);
        chk(rsp_addr === exp_addr, {tag, " addr"}, rsp_addr, exp_addr);
        chk(rsp_pass === exp_pass, {tag, " pass"}, 64'(rsp_pass), 64'(exp_pass));
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(rsp_valid === 1'b0, {tag, " R10 consumed"}, 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(rsp_valid === 1'b0, "R11 rsp_valid", 64'(rsp_valid), 64'd0);
        chk(rsp_pass === 1'b0, "R11 rsp_pass", 64'(rsp_pass), 64'd0);
        chk(rsp_addr === 64'd0, "R11 rsp_addr", rsp_addr, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_lower_pass();
        // R1 R3 R5 R6: lower half, T=16, no top-byte-ignore
        logic [63:0] p = 64'h1234_5678_9ABC_DEF0;
        run_req("R5 lower canon", p, p, mk_tctl(16, 39, 0, 1, 0, 0, 1, 0), 1, 0, 1, 1, 0,
                64'h0000_5678_9ABC_DEF0, 1, 0);
    endtask

    task automatic t_upper_pass();
        // R1 R4 R5: upper half, T=39 -> bits 54:25, top byte kept
        logic [63:0] p = 64'h5A80_0000_0000_1234;
        run_req("R1 upper canon", p, p, mk_tctl(16, 39, 0, 1, 0, 0, 0, 0), 1, 0, 1, 1, 0,
                64'h5AFF_FFFF_FE00_1234, 1, 0);
    endtask

    task automatic t_clamp();
        // R4: size 63 clamps to 39 so bit 25 is a code bit
        run_req("R4 clamp high", 64'h0000_0000_0000_1234, 64'h0000_0000_0200_1234,
                mk_tctl(63, 0, 1, 0, 0, 0, 0, 0), 1, 0, 1, 1, 0,
                64'h0020_0000_0000_1234, 0, 0);
        // R4: size 3 clamps to 16 so bit 47 is not a code bit
        run_req("R4 clamp low", 64'h0000_0000_0000_1234, 64'h0000_8000_0000_1234,
                mk_tctl(3, 0, 1, 0, 0, 0, 0, 0), 1, 0, 1, 1, 0,
                64'h0000_0000_0000_1234, 1, 0);
    endtask

    task automatic t_fail_codes();
        logic [63:0] p = 64'h0000_5678_9ABC_DEF0;
        logic [63:0] c = 64'h0001_0000_0000_0000;
        // R8: key A, top-byte-ignore effective -> 54:53 = 1
        run_req("R8 keyA tbi", p, c, mk_tctl(16, 16, 1, 0, 0, 0, 0, 0), 1, 0, 1, 1, 0,
                64'h0020_5678_9ABC_DEF0, 0, 0);
        // R8 R3: key B, not effective -> 62:61 = 2
        run_req("R8 keyB notbi", p, c, mk_tctl(16, 16, 0, 0, 0, 0, 0, 0), 1, 1, 1, 1, 0,
                64'h4000_5678_9ABC_DEF0, 0, 0);
        // R9: enhanced scheme XOR
        run_req("R9 enh xor", p, c, mk_tctl(16, 16, 1, 0, 0, 0, 0, 0), 1, 0, 1, 1, 1,
                64'h0001_5678_9ABC_DEF0, 0, 0);
    endtask

    task automatic t_disabled();
        // R7: key B disabled, mismatching code, pointer returned unchanged
        logic [63:0] p = 64'hFF34_5678_9ABC_DEF0;
        run_req("R7 key off", p, 64'h0, mk_tctl(16, 16, 0, 0, 0, 0, 0, 0), 1, 1, 1, 0, 0,
                p, 1, 0);
    endtask

    task automatic t_no_host_ext();
        // R2: bit 55 ignored, bit 20 TBI used with lower size field
        logic [63:0] p = 64'h5A80_0000_0000_1234;
        run_req("R2 single tbi", p, p, mk_tctl(16, 39, 0, 0, 0, 0, 1, 0), 0, 0, 1, 1, 0,
                64'h5AFF_0000_0000_1234, 1, 0);
        // R2: bit 29 TBID cancels bit 20 TBI
        run_req("R2 single tbid", 64'h1200_0000_0000_1234, 64'h1200_0000_0000_1234,
                mk_tctl(16, 39, 1, 1, 0, 0, 1, 1), 0, 0, 1, 1, 0,
                64'h0000_0000_0000_1234, 1, 0);
    endtask

    task automatic t_tbid();
        // R3: TBID set -> top byte joins the mask
        logic [63:0] p = 64'hAB00_1111_2222_3333;
        run_req("R3 tbid", p, p, mk_tctl(16, 16, 1, 0, 1, 0, 0, 0), 1, 0, 1, 1, 0,
                64'h0000_1111_2222_3333, 1, 0);
    endtask

    task automatic t_stall();
        // R10: response held across three stall cycles; R6 mismatch key A
        logic [63:0] p = 64'h0000_5678_9ABC_DEF0;
        run_req("R10 stall", p, 64'h0001_0000_0000_0000, mk_tctl(16, 16, 1, 0, 0, 0, 0, 0),
                1, 0, 1, 1, 0, 64'h0020_5678_9ABC_DEF0, 0, 3);
    endtask

    task automatic t_sweep();
        // R6 R4 R1: mixed vectors against the requirement model
        logic [63:0] lf = 64'h9E37_79B9_7F4A_7C15;
        for (int k = 0; k < 24; k++) begin
            logic [63:0] p, c, t;
            logic [64:0] e;
            bit hx, kb, en;
            lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]} ^ 64'(k * 977);
            p  = lf;
            c  = (k % 3 == 0) ? p : (p ^ (64'd1 << (20 + k)));
            t  = mk_tctl(k * 3, 63 - k * 2, k[0], k[1], k[2], k[3], k[1], k[0]);
            hx = (k % 4 != 3);
            kb = k[2];
            en = k[1];
            e  = model(p, c, t, hx, kb, 1, 1, en);
            run_req("R6 sweep", p, c, t, hx, kb, 1, 1, en, e[63:0], e[64], 0);
        end
    endtask

    initial begin
        t_reset();
        t_lower_pass();
        t_upper_pass();
        t_clamp();
        t_fail_codes();
        t_disabled();
        t_no_host_ext();
        t_tbid();
        t_stall();
        t_sweep();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R10 actual=%h expected=%h", 64'd0, 64'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule